// File: doc/BRIEF.md
# Raster Line Pixel Serializer

This block turns a stream of 16-bit bitmap words into a one-bit pixel stream, one raster scan line at a time. A memory-fetch engine outside the block writes words into a small internal word buffer. The block shows a left margin of background, then the bits of the line's words with the most significant bit first, then background until the last pixel position of the line. While a line is armed or running, the block requests a word whenever the buffer has room and the line still needs words. The fetch engine can therefore fill the buffer during blanking and top it up while pixels are being shown.

A line runs in two steps. A one-cycle `line_arm` pulse latches the per-line controls, empties the buffer, clears the underflow flag and opens requests. A later one-cycle `line_go` pulse starts pixel output. The per-line controls are:
- a resolution mode: in low resolution each pixel position is held for two clocks, and the memory format does not change;
- a polarity bit that inverts the whole line;
- a left margin counted in units of 16 pixel positions;
- a count of data words.

Top module: `scanline_serializer`

## Requirements
- R1: After reset, `pix_valid`, `pix_out`, `word_req` and `underflow` are all 0.
- R2: The clock after `line_go` is accepted in the armed state, `pix_valid` is 1 for exactly 606 clocks in high resolution (`cfg_lowres`=0), or 1212 clocks in low resolution. It is 0 on the clock after that.
- R3: Pixel positions below 16×margin show background. `pix_out` is 1 for light and 0 for dark. Background is 1 when the polarity bit is 0 and 0 when it is 1.
- R4: Position margin×16 + 16k + j (j = 0..15) shows bit 15−j of the k-th word accepted since arm, so the MSB comes first. With polarity 0 a set bit gives 0 (dark on light). With polarity 1 the output equals the bit.
- R5: Positions at or beyond 16×(margin+words) show background, and so does the whole line when the word count is 0. The line always ends after position 605, and data that would fall beyond that position is clipped.
- R6: In low-resolution mode each pixel position is held for two consecutive clocks. The words and bit order are the same as in high resolution.
- R7: `word_req` is 1 only while a line is armed or running, the buffer holds fewer than 16 words, and fewer words than the word count have been accepted. A `wr_valid` while `word_req` is 0 stores nothing.
- R8: The buffer holds at most 16 words. After 16 accepted words with no pixel consumption, `word_req` is 0.
- R9: If a data position is reached while the buffer is empty, that pixel shows background and `underflow` rises on the next clock. It stays 1 until the next arm and is never set while the buffer supplies data.
- R10: `line_arm` empties the buffer and latches the controls. Changes to the control inputs after the arm have no effect on the line. Words left over from a previous line are never shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_arm | input | 1 | Latch controls, empty buffer, open requests |
| line_go | input | 1 | Start pixel output of an armed line |
| cfg_lowres | input | 1 | 1 = half pixel rate |
| cfg_invert | input | 1 | Polarity: 0 = dark on light, 1 = light on dark |
| cfg_margin | input | 6 | Left margin in 16-pixel units |
| cfg_words | input | 8 | Data words on the line |
| wr_valid | input | 1 | Word offered by the fetch engine |
| wr_data | input | 16 | Offered bitmap word |
| word_req | output | 1 | Buffer accepts a word this clock |
| pix_valid | output | 1 | Line pixel output active |
| pix_out | output | 1 | Pixel level, 1 = light |
| underflow | output | 1 | Sticky: a data pixel found the buffer empty |

## Verification
A buffer write and the pop of a fully shown word can fall on the same clock. The bench provokes this by keeping the fetch model running through every line. The buffer then sits at or near full, and each pop at a word boundary is met by a push on that clock or the next. The result is judged on the pixel stream, which must match the arithmetic expectation bit for bit with `underflow` still 0 at the end of the line. The second case is a data position that meets an empty buffer. The bench produces it by starving the buffer, and it checks both the background pixel and the flag's rise one clock after the first starved position.

// File: rtl/scanline_pkg.sv
package scanline_pkg;
   typedef enum logic [1:0] {
      LS_IDLE   = 2'd0,
      LS_ARMED  = 2'd1,
      LS_ACTIVE = 2'd2
   } line_state_e;
endpackage

// File: rtl/sl_word_fifo.sv
module sl_word_fifo #(
   parameter int WORD_W = 16,
   parameter int DEPTH  = 16,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              push,
   input  logic [WORD_W-1:0] din,
   input  logic              pop,
   output logic [WORD_W-1:0] dout,
   output logic              empty,
   output logic              full
);
   logic [WORD_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CNT_W-1:0]  level;
   logic              do_push, do_pop;

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("sl_word_fifo: DEPTH must be at least 2");
      end
      if ((1 << PTR_W) == DEPTH) begin : g_wrap_pow2
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap_mod
         assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   assign empty   = (level == '0);
   assign full    = (level == CNT_W'(DEPTH));
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         case ({do_push, do_pop})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (do_push && !flush) mem[wr_ptr] <= din;
   end

   assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      level <= CNT_W'(DEPTH));
   assert_no_push_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> !push);
endmodule

// File: rtl/sl_pixel_timer.sv
module sl_pixel_timer
   import scanline_pkg::*;
#(
   parameter int LINE_PIXELS = 606,
   localparam int POS_W = $clog2(LINE_PIXELS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm,
   input  logic             go,
   input  logic             lowres,
   output line_state_e      state,
   output logic [POS_W-1:0] pos,
   output logic             last_phase
);
   logic phase;

   generate
      if (LINE_PIXELS < 2) begin : g_bad_len
         $error("sl_pixel_timer: LINE_PIXELS must be at least 2");
      end
   endgenerate

   assign last_phase = !lowres || phase;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= LS_IDLE;
         pos   <= '0;
         phase <= 1'b0;
      end else if (arm) begin
         state <= LS_ARMED;
         pos   <= '0;
         phase <= 1'b0;
      end else begin
         case (state)
            LS_ARMED: if (go) state <= LS_ACTIVE;
            LS_ACTIVE: begin
               phase <= lowres ? ~phase : 1'b0;
               if (last_phase) begin
                  if (pos == POS_W'(LINE_PIXELS - 1)) begin
                     state <= LS_IDLE;
                     pos   <= '0;
                  end else begin
                     pos <= pos + 1'b1;
                  end
               end
            end
            default: state <= LS_IDLE;
         endcase
      end
   end

   assert_hold_lowres_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == LS_ACTIVE && !last_phase && !arm) |=> (state == LS_ACTIVE && pos == $past(pos)));
   assert_pos_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == LS_ACTIVE) |-> (pos < POS_W'(LINE_PIXELS)));
endmodule

// File: rtl/sl_fetch_gate.sv
module sl_fetch_gate #(
   parameter int COUNT_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               arm,
   input  logic               open,
   input  logic               full,
   input  logic [COUNT_W-1:0] nwords,
   input  logic               wr_valid,
   output logic               word_req,
   output logic               push
);
   logic [COUNT_W-1:0] accepted;

   assign word_req = open && !full && (accepted < nwords);
   assign push     = wr_valid && word_req;

   always_ff @(posedge clk) begin
      if (!rst_n || arm) accepted <= '0;
      else if (push)     accepted <= accepted + 1'b1;
   end

   assert_acc_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      accepted <= nwords);
endmodule

// File: rtl/scanline_serializer.sv
module scanline_serializer
   import scanline_pkg::*;
#(
   parameter int WORD_W      = 16,
   parameter int BUF_DEPTH   = 16,
   parameter int LINE_PIXELS = 606,
   parameter int MARGIN_W    = 6,
   parameter int COUNT_W     = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                line_arm,
   input  logic                line_go,
   input  logic                cfg_lowres,
   input  logic                cfg_invert,
   input  logic [MARGIN_W-1:0] cfg_margin,
   input  logic [COUNT_W-1:0]  cfg_words,
   input  logic                wr_valid,
   input  logic [WORD_W-1:0]   wr_data,
   output logic                word_req,
   output logic                pix_valid,
   output logic                pix_out,
   output logic                underflow
);
   localparam int BIT_W  = $clog2(WORD_W);
   localparam int POS_W  = $clog2(LINE_PIXELS);
   localparam int SPAN_W = ((MARGIN_W > COUNT_W) ? MARGIN_W : COUNT_W) + 1 + BIT_W;
   localparam logic [BIT_W-1:0] TOP_IDX = BIT_W'(WORD_W - 1);

   generate
      if (WORD_W != (1 << BIT_W)) begin : g_bad_word
         $error("scanline_serializer: WORD_W must be a power of two");
      end
      if (POS_W > SPAN_W) begin : g_bad_span
         $error("scanline_serializer: line longer than the control fields can address");
      end
   endgenerate

   // latched per-line controls
   logic                lowres_q, inv_q;
   logic [MARGIN_W-1:0] margin_q;
   logic [COUNT_W-1:0]  words_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lowres_q <= 1'b0;
         inv_q    <= 1'b0;
         margin_q <= '0;
         words_q  <= '0;
      end else if (line_arm) begin
         lowres_q <= cfg_lowres;
         inv_q    <= cfg_invert;
         margin_q <= cfg_margin;
         words_q  <= cfg_words;
      end
   end

   line_state_e      state;
   logic [POS_W-1:0] pos;
   logic             last_phase;

   sl_pixel_timer #(.LINE_PIXELS(LINE_PIXELS)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .arm        (line_arm),
      .go         (line_go),
      .lowres     (lowres_q),
      .state      (state),
      .pos        (pos),
      .last_phase (last_phase)
   );

   logic              buf_full, buf_empty, push, pop;
   logic [WORD_W-1:0] head;

   sl_fetch_gate #(.COUNT_W(COUNT_W)) u_gate (
      .clk      (clk),
      .rst_n    (rst_n),
      .arm      (line_arm),
      .open     (state != LS_IDLE),
      .full     (buf_full),
      .nwords   (words_q),
      .wr_valid (wr_valid),
      .word_req (word_req),
      .push     (push)
   );

   sl_word_fifo #(.WORD_W(WORD_W), .DEPTH(BUF_DEPTH)) u_buf (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (line_arm),
      .push  (push),
      .din   (wr_data),
      .pop   (pop),
      .dout  (head),
      .empty (buf_empty),
      .full  (buf_full)
   );

   // position decode: margin is a whole number of words, so the bit index is pos's low bits
   logic [SPAN_W-1:0] start_px, end_px, pos_x;
   logic              in_data, active, data_bit;
   logic [BIT_W-1:0]  bit_idx;

   assign active   = (state == LS_ACTIVE);
   assign start_px = SPAN_W'(margin_q) << BIT_W;
   assign end_px   = (SPAN_W'(margin_q) + SPAN_W'(words_q)) << BIT_W;
   assign pos_x    = SPAN_W'(pos);
   assign in_data  = (pos_x >= start_px) && (pos_x < end_px);
   assign bit_idx  = TOP_IDX - pos[BIT_W-1:0];
   assign data_bit = in_data && !buf_empty && head[bit_idx];
   assign pop      = active && in_data && last_phase && (pos[BIT_W-1:0] == TOP_IDX);

   assign pix_valid = active;
   assign pix_out   = active && (data_bit ^ ~inv_q);

   always_ff @(posedge clk) begin
      if (!rst_n || line_arm)              underflow <= 1'b0;
      else if (active && in_data && buf_empty) underflow <= 1'b1;
   end

   assert_bg_outside_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && !in_data) |-> (pix_out == !inv_q));
   assert_starve_bg_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && buf_empty) |-> (pix_out == !inv_q));
   assert_underflow_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (underflow && !line_arm) |=> underflow);
   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_valid |-> !pix_out);
endmodule

// File: tb/scanline_serializer_tb.sv
`timescale 1ns/1ps
module scanline_serializer_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        line_arm = 1'b0, line_go = 1'b0;
   logic        cfg_lowres = 1'b0, cfg_invert = 1'b0;
   logic [5:0]  cfg_margin = '0;
   logic [7:0]  cfg_words = '0;
   logic        wr_valid = 1'b0;
   logic [15:0] wr_data = '0;
   logic        word_req, pix_valid, pix_out, underflow;

   int n_checks = 0, n_fail = 0;
   int acc = 0;
   bit real_q = 0, fetch_en = 0, junk_en = 0;
   int cur_seed = 0;

   always #2.5 clk = ~clk;

   scanline_serializer u_dut (
      .clk(clk), .rst_n(rst_n), .line_arm(line_arm), .line_go(line_go),
      .cfg_lowres(cfg_lowres), .cfg_invert(cfg_invert), .cfg_margin(cfg_margin),
      .cfg_words(cfg_words), .wr_valid(wr_valid), .wr_data(wr_data),
      .word_req(word_req), .pix_valid(pix_valid), .pix_out(pix_out), .underflow(underflow)
   );

   function automatic logic [15:0] wgen(int seed, int k);
      return 16'((seed * 40503 + k * 9973) ^ (k << 7) ^ (seed << 3));
   endfunction

   function automatic bit exp_pix(int p, bit inv, int m, int n, int seed, bit starve);
      bit b = 0;
      logic [15:0] w;
      if (!starve && p >= m * 16 && p < (m + n) * 16) begin
         w = wgen(seed, (p - m * 16) / 16);
         b = w[15 - (p % 16)];
      end
      return b ^ !inv;
   endfunction

   task automatic chk(bit ok, string req, int act, int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // one clock: wait for the falling edge, then play the fetch engine
   task automatic tick();
      @(negedge clk);
      if (real_q) acc++;
      real_q   = 0;
      wr_valid = 1'b0;
      if (fetch_en && word_req) begin
         wr_valid = 1'b1;
         wr_data  = wgen(cur_seed, acc);
         real_q   = 1;
      end else if (junk_en && !word_req) begin
         wr_valid = 1'b1;
         wr_data  = 16'hFFFF;
      end
   endtask

   task automatic run_line(bit lowres, bit inv, int m, int n, int seed, int prefill,
                           bit fetch_on, bit junk, int exp_acc, bit exp_req, string tag);
      int len, bad, first_c, first_a, first_e;
      bit starve;
      starve = !fetch_on;
      fetch_en = 0; junk_en = 0;
      tick();
      cur_seed   = seed;
      cfg_lowres = lowres; cfg_invert = inv;
      cfg_margin = 6'(m);  cfg_words  = 8'(n);
      line_arm   = 1'b1;
      tick();
      line_arm = 1'b0; acc = 0; real_q = 0;
      chk(underflow == 1'b0, "R10 arm clears underflow", underflow, 0);
      // R10: scramble controls after the arm
      cfg_lowres = ~lowres; cfg_invert = ~inv;
      cfg_margin = 6'(m) ^ 6'h15; cfg_words = 8'(n) ^ 8'h5A;
      fetch_en = fetch_on; junk_en = junk;
      for (int i = 0; i < prefill; i++) tick();
      if (exp_acc >= 0) begin
         chk(acc == exp_acc, {tag, " words accepted before go"}, acc, exp_acc);
         chk(word_req == exp_req, {tag, " word_req after prefill"}, word_req, exp_req);
      end
      junk_en = 0;
      line_go = 1'b1;
      len = lowres ? 1212 : 606;
      bad = 0; first_c = -1; first_a = 0; first_e = 0;
      for (int c = 0; c < len; c++) begin
         int p;
         bit e;
         tick();
         if (c == 0) line_go = 1'b0;
         p = lowres ? c / 2 : c;
         e = exp_pix(p, inv, m, n, seed, starve);
         if (pix_valid !== 1'b1 || pix_out !== e) begin
            if (first_c < 0) begin first_c = c; first_a = {pix_valid, pix_out}; first_e = {1'b1, e}; end
            bad++;
         end
         if (starve && !lowres && m * 16 + 1 < len && n > 0) begin
            if (p == m * 16) chk(underflow == 1'b0, "R9 underflow not yet", underflow, 0);
            if (p == m * 16 + 1) chk(underflow == 1'b1, "R9 underflow rises", underflow, 1);
         end
      end
      if (bad != 0) $display("FAIL %s pixel stream clock %0d actual={valid,pix}=%0d expected=%0d (%0d bad)",
                             tag, first_c, first_a, first_e, bad);
      n_checks++; if (bad != 0) n_fail++;
      tick();
      chk(pix_valid == 1'b0, {tag, " R2 line ends"}, pix_valid, 0);
      chk(underflow == (starve && n > 0 && m * 16 < 606), {tag, " R9 underflow at end"},
          underflow, int'(starve && n > 0 && m * 16 < 606));
      fetch_en = 0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++; n_checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (3) tick();
      chk(pix_valid == 0 && pix_out == 0, "R1 reset pixel outputs", {pix_valid, pix_out}, 0);
      chk(word_req == 0 && underflow == 0, "R1 reset req/underflow", {word_req, underflow}, 0);
      rst_n = 1'b1;
      tick();
      chk(word_req == 0, "R1 idle after reset", word_req, 0);
      // R4 R5 full width, last two bits clipped
      run_line(0, 0, 0, 38, 1, 20, 1, 0, -1, 0, "R4 R5 full width");
      run_line(0, 1, 3, 10, 2, 20, 1, 0, -1, 0, "R3 R4 inverted margin");
      run_line(1, 0, 5, 12, 3, 20, 1, 0, -1, 0, "R6 lowres");
      run_line(1, 1, 0, 38, 4, 20, 1, 0, -1, 0, "R6 lowres inverted");
      run_line(0, 0, 2, 0, 5, 20, 1, 0, 0, 0, "R5 zero words");
      run_line(0, 1, 63, 200, 6, 20, 1, 0, -1, 0, "R5 margin past line");
      // R8 buffer limit: 16 accepted, request low; leftover words then flushed by R10
      run_line(0, 1, 1, 40, 7, 25, 1, 0, 16, 0, "R8 buffer full");
      // R7 word count limit plus ignored writes
      run_line(0, 0, 4, 3, 8, 25, 1, 1, 3, 0, "R7 count limit and ignored write");
      // R9 starved line, then R10 next arm clears the flag
      run_line(0, 0, 2, 4, 9, 0, 0, 0, -1, 0, "R9 starved");
      run_line(0, 0, 1, 6, 10, 20, 1, 0, -1, 0, "R10 after starve");
      // sweep of margins with widths filling the line
      for (int m = 0; m < 38; m += 4)
         run_line(m % 8 == 4, m % 3 == 1, m, 38 - m + (m % 5), 20 + m, 20, 1, 0, -1, 0, "R3 R4 sweep");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule